// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block sits between a duty-cycle comparator and a pair of gate-drive pins, a high-side pin and a low-side pin. In complementary mode the high pin follows the duty signal and the low pin follows its inverse. Whenever the duty signal changes level, both pins are held inactive for a programmable interval before the newly active pin is allowed on. This keeps the two switches of a half bridge from conducting at the same time.

The interval is a 6-bit unsigned count. A prescaler, selectable as 1, 2, 4 or 8 clocks per step, slows the count. The count value and the prescaler choice are captured on a configuration write strobe. An independent mode drops the dead time altogether: both pins then follow the duty signal directly, and each pin can be switched to pass the PWM signal, be forced low, or be forced high.

Top module: `pwm_deadband`

## Requirements
- R1: While rst_ni is low, hi_o is 0 and lo_o is 1. The captured dead time and the prescaler select are both 0.
- R2: In complementary mode (indep_i = 0), when no dead-time count is running, hi_o equals duty_i as sampled at the previous rising clock edge and lo_o is its inverse. hi_o and lo_o are never both 1.
- R3: In complementary mode, each change of the sampled duty signal drives both pins to 0 for exactly D x 2^S clock cycles, starting with the cycle after the sampling edge. D is the captured dead-time value and S is the captured prescaler select (0 means 1 clock per step, 1 means 2, 2 means 4, 3 means 8). After that interval the new pin turns on.
- R4: With a captured dead-time value of 0, the pins switch over in the cycle after the duty change, with no gap.
- R5: A duty change that arrives while a count is running reloads the count with D and clears the prescaler. Both pins stay 0 until the new count of D x 2^S cycles expires.
- R6: A configuration write (cfg_we_i = 1) clears the prescaler. A write that lands j cycles after a duty change, with 0 < j < 2^S, lengthens the running gap by j cycles.
- R7: A duty-change load clears the prescaler, so every gap is measured from the duty change no matter what the prescaler held before.
- R8: dt_val_i and pre_sel_i are captured only on a rising edge where cfg_we_i = 1. Changes to them at any other time do not affect the gap.
- R9: In independent mode (indep_i = 1) with both overrides set to PWM, both pins equal the sampled duty signal. No gap is inserted, and both pins may be 1 at the same time.
- R10: Override code per pin: 2'b00 and 2'b11 pass the PWM signal, 2'b01 forces the pin to 0, and 2'b10 forces it to 1. Overrides act only in independent mode and are ignored in complementary mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| duty_i | input | 1 | Duty-cycle comparison signal |
| cfg_we_i | input | 1 | Configuration write strobe; captures dt_val_i and pre_sel_i |
| pre_sel_i | input | 2 | Prescaler select (2^value clocks per count step) |
| dt_val_i | input | 6 | Dead-time count value |
| indep_i | input | 1 | 1 selects independent mode, 0 selects complementary mode |
| ovr_hi_i | input | 2 | High-pin override code (independent mode only) |
| ovr_lo_i | input | 2 | Low-pin override code (independent mode only) |
| hi_o | output | 1 | High-side pin, active high |
| lo_o | output | 1 | Low-side pin, active high |

## Verification
The hardest situation to reach from the ports is a configuration write that falls in the middle of a prescaled step while a gap is running. The only visible effect is that the gap gets longer by exactly the number of cycles the prescaler had already counted. To reach it, the bench programs a 4-clock step, starts a gap, and raises the strobe three cycles after the duty change while rewriting the same values. It then expects an 11-cycle gap instead of 8. A second tricky case is a duty change in the middle of a gap. The bench flips the duty twice, two cycles apart, and checks that the gap restarts from the second change.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  typedef enum logic [1:0] {
    OVR_PWM   = 2'b00,
    OVR_LOW   = 2'b01,
    OVR_HIGH  = 2'b10,
    OVR_PWM_B = 2'b11
  } ovr_e;

  localparam int unsigned NUM_PINS = 2;
  localparam int unsigned PIN_HI   = 0;
  localparam int unsigned PIN_LO   = 1;
endpackage

// File: rtl/pwm_dt_edge.sv
module pwm_dt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic duty_i,
  output logic level_o,
  output logic edge_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= duty_i;
  end

  assign edge_o  = duty_i ^ level_q;
  assign level_o = level_q;
endmodule

// File: rtl/pwm_dt_prescale.sv
module pwm_dt_prescale #(
  parameter int unsigned PRE_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CW = (1 << PRE_W) - 1;

  logic [CW-1:0] pre_q;
  logic [CW-1:0] lim;

  // limit = 2^sel - 1
  always_comb begin
    lim = '0;
    for (int i = 0; i < CW; i++) begin
      if (i < int'(sel_i)) lim[i] = 1'b1;
    end
  end

  assign tick_o = run_i && (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_dt_counter.sv
module pwm_dt_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_dt_pinmux.sv
module pwm_dt_pinmux
  import pwm_dt_pkg::*;
(
  input  logic       indep_i,
  input  logic       level_i,
  input  logic       busy_i,
  input  logic [1:0] ovr_hi_i,
  input  logic [1:0] ovr_lo_i,
  output logic       hi_o,
  output logic       lo_o
);
  logic [NUM_PINS-1:0] comp;
  logic [NUM_PINS-1:0] pin;
  logic [1:0]          ovr [NUM_PINS];

  assign ovr[PIN_HI]  = ovr_hi_i;
  assign ovr[PIN_LO]  = ovr_lo_i;
  assign comp[PIN_HI] = level_i & ~busy_i;
  assign comp[PIN_LO] = ~level_i & ~busy_i;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_comb begin
      if (!indep_i) begin
        pin[g] = comp[g];
      end else begin
        unique case (ovr_e'(ovr[g]))
          OVR_LOW:  pin[g] = 1'b0;
          OVR_HIGH: pin[g] = 1'b1;
          default:  pin[g] = level_i;
        endcase
      end
    end
  end

  assign hi_o = pin[PIN_HI];
  assign lo_o = pin[PIN_LO];
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned PRE_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             duty_i,
  input  logic             cfg_we_i,
  input  logic [PRE_W-1:0] pre_sel_i,
  input  logic [CNT_W-1:0] dt_val_i,
  input  logic             indep_i,
  input  logic [1:0]       ovr_hi_i,
  input  logic [1:0]       ovr_lo_i,
  output logic             hi_o,
  output logic             lo_o
);
  logic [CNT_W-1:0] dt_q;
  logic [PRE_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             level_s, edge_s, tick_s, busy_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dt_q  <= '0;
      sel_q <= '0;
    end else if (cfg_we_i) begin
      dt_q  <= dt_val_i;
      sel_q <= pre_sel_i;
    end
  end

  pwm_dt_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .duty_i  (duty_i),
    .level_o (level_s),
    .edge_o  (edge_s)
  );

  assign busy_s = |cnt_q;

  pwm_dt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (edge_s | cfg_we_i),
    .run_i  (busy_s),
    .sel_i  (sel_q),
    .tick_o (tick_s)
  );

  pwm_dt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (edge_s),
    .val_i  (dt_q),
    .tick_i (tick_s),
    .cnt_o  (cnt_q)
  );

  pwm_dt_pinmux u_mux (
    .indep_i  (indep_i),
    .level_i  (level_s),
    .busy_i   (busy_s),
    .ovr_hi_i (ovr_hi_i),
    .ovr_lo_i (ovr_lo_i),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
  );
endmodule

// File: rtl/pwm_deadband_chk.sv
module pwm_deadband_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             indep_i,
  input logic [1:0]       ovr_hi_i,
  input logic [1:0]       ovr_lo_i,
  input logic             hi_o,
  input logic             lo_o,
  input logic             edge_s,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] dt_q
);
  p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !indep_i |-> !(hi_o && lo_o));

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_s |=> cnt_q == $past(dt_q));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !edge_s) |=>
      (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  p_gap_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!indep_i && cnt_q != '0) |-> (!hi_o && !lo_o));

  p_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!indep_i && cnt_q == '0) |-> (hi_o ^ lo_o));

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(dt_q));

  p_indep_same_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (indep_i && ovr_hi_i == 2'b00 && ovr_lo_i == 2'b00) |-> (hi_o == lo_o));
endmodule

bind pwm_deadband pwm_deadband_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .indep_i  (indep_i),
  .ovr_hi_i (ovr_hi_i),
  .ovr_lo_i (ovr_lo_i),
  .hi_o     (hi_o),
  .lo_o     (lo_o),
  .edge_s   (edge_s),
  .cnt_q    (cnt_q),
  .dt_q     (dt_q)
);

// File: tb/pwm_deadband_tb_top.sv
module pwm_deadband_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       duty_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] pre_sel_i = '0;
  logic [5:0] dt_val_i = '0;
  logic       indep_i = 1'b0;
  logic [1:0] ovr_hi_i = '0;
  logic [1:0] ovr_lo_i = '0;
  logic       hi_o, lo_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] q_v[$];
  string      q_r[$];

  always #4 clk_i = ~clk_i;

  pwm_deadband dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .duty_i(duty_i), .cfg_we_i(cfg_we_i),
    .pre_sel_i(pre_sel_i), .dt_val_i(dt_val_i), .indep_i(indep_i),
    .ovr_hi_i(ovr_hi_i), .ovr_lo_i(ovr_lo_i), .hi_o(hi_o), .lo_o(lo_o)
  );

  // monitor: compares pins shortly after each edge with the queued expectation
  always @(posedge clk_i) begin
    #2;
    if (q_v.size() > 0) begin
      logic [1:0] v;
      string r;
      v = q_v.pop_front();
      r = q_r.pop_front();
      checks++;
      if ({hi_o, lo_o} !== v) begin
        fails++;
        $display("FAIL %s: hi/lo actual %b%b expected %b%b at %0t", r, hi_o, lo_o, v[1], v[0], $time);
      end
    end
  end

  // called at a falling edge with inputs already set; expectation is for the next rising edge
  task automatic cyc(input logic eh, input logic el, input string r);
    q_v.push_back({eh, el});
    q_r.push_back(r);
    @(negedge clk_i);
  endtask

  task automatic toggle(input logic d, input int gap, input int hold, input string r);
    duty_i = d;
    for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, r);
    for (int i = 0; i < hold; i++) cyc(d, ~d, r);
  endtask

  task automatic cfg(input logic [5:0] dt, input logic [1:0] sel, input logic eh, input logic el);
    cfg_we_i = 1'b1; dt_val_i = dt; pre_sel_i = sel;
    cyc(eh, el, "R8");
    cfg_we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (!(hi_o === 1'b0 && lo_o === 1'b1)) begin
      fails++;
      $display("FAIL R1: reset hi/lo actual %b%b expected 01", hi_o, lo_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    cfg(6'd3, 2'd0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, "R2");
    cyc(1'b0, 1'b1, "R2");
    toggle(1'b1, 3, 4, "R3");                // 3 x 1
    cfg(6'd2, 2'd2, 1'b1, 1'b0);
    toggle(1'b0, 8, 3, "R3");                // 2 x 4
    toggle(1'b1, 8, 3, "R7");
    dt_val_i = 6'd5; pre_sel_i = 2'd0;       // no strobe: ignored
    toggle(1'b0, 8, 3, "R8");
    cfg(6'd1, 2'd3, 1'b0, 1'b1);
    toggle(1'b1, 8, 3, "R3");                // 1 x 8
    cfg(6'd3, 2'd1, 1'b1, 1'b0);
    toggle(1'b0, 6, 3, "R3");                // 3 x 2
    cfg(6'd0, 2'd2, 1'b0, 1'b1);
    toggle(1'b1, 0, 3, "R4");
    toggle(1'b0, 0, 3, "R4");

    // reload during a running count
    cfg(6'd4, 2'd0, 1'b0, 1'b1);
    toggle(1'b1, 2, 0, "R5");
    toggle(1'b0, 4, 3, "R5");

    // config write three cycles into a 4-clock step: 8 + 3 cycles
    cfg(6'd2, 2'd2, 1'b0, 1'b1);
    toggle(1'b1, 3, 0, "R6");
    cfg_we_i = 1'b1;
    cyc(1'b0, 1'b0, "R6");
    cfg_we_i = 1'b0;
    for (int i = 0; i < 7; i++) cyc(1'b0, 1'b0, "R6");
    cyc(1'b1, 1'b0, "R6");
    cyc(1'b1, 1'b0, "R6");

    // overrides ignored in complementary mode
    ovr_hi_i = 2'b01; ovr_lo_i = 2'b10;
    cyc(1'b1, 1'b0, "R10");
    cyc(1'b1, 1'b0, "R10");

    // independent mode
    indep_i = 1'b1; ovr_hi_i = 2'b00; ovr_lo_i = 2'b00;
    cyc(1'b1, 1'b1, "R9");
    duty_i = 1'b0; cyc(1'b0, 1'b0, "R9");
    duty_i = 1'b1; cyc(1'b1, 1'b1, "R9");
    ovr_hi_i = 2'b01; cyc(1'b0, 1'b1, "R10");
    ovr_hi_i = 2'b10; ovr_lo_i = 2'b01; cyc(1'b1, 1'b0, "R10");
    duty_i = 1'b0; ovr_lo_i = 2'b10; cyc(1'b1, 1'b1, "R10");
    ovr_hi_i = 2'b11; cyc(1'b0, 1'b1, "R10");
    ovr_hi_i = 2'b00; ovr_lo_i = 2'b00;
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, "R9");
    indep_i = 1'b0;
    cyc(1'b0, 1'b1, "R2");
    cyc(1'b0, 1'b1, "R2");

    @(posedge clk_i); #3;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule